// File: doc/BRIEF.md
# Sixteen-Bit ALU with Registered Status Flags

This block is the arithmetic and logic stage of a small processor execution unit. It takes two 16-bit operands, a 4-bit operation code and a size select. It produces the result combinationally in the same cycle. The result can be a sum, a difference, an increment or decrement of the first operand, a bitwise logic function, a one's complement or a one-bit shift.

Six status flags describe that result: carry, parity, auxiliary carry, zero, sign and overflow. They are captured into a 16-bit flag word on the rising clock edge when the flag-write strobe is high. At any other time the word holds its value, so the rest of the pipeline sees the flags of the last operation that was committed.

In byte mode only the low eight bits of each operand take part. Carry, sign and overflow are then taken at bit 7, and the upper result byte reads as zero.

Top module: `alu16_core`

## Requirements
- R1: Operation code 0 (add) gives op_a + op_b modulo the selected width. Carry is set when a carry leaves the top bit of that width.
- R2: Operation code 1 (subtract) gives op_a - op_b modulo the selected width. Carry is set when a borrow is needed, that is when op_a is less than op_b as unsigned numbers.
- R3: Auxiliary carry is set on a carry out of bit 3 for add and increment, and on a borrow into bit 3 for subtract and decrement. It is 0 after every logic or shift operation.
- R4: Parity is 1 when the low byte of the result holds an even number of ones, and 0 when it holds an odd number.
- R5: Zero is set when the result in the selected width equals zero. Sign equals the top bit of the selected width (bit 7 in byte mode, bit 15 in word mode).
- R6: Overflow rules:
  - Add and increment: overflow is set when both inputs have the same sign and the result sign differs from op_a.
  - Subtract and decrement: overflow is set when the inputs have different signs and the result sign differs from op_a.
  - Shift left: overflow equals the new top bit XOR carry.
  - Shift right: overflow equals the old top bit of op_a.
- R7: Operation codes 5 (increment, op_a + 1) and 6 (decrement, op_a - 1) update every status flag except carry, which keeps its previous value.
- R8: Operation codes 2 (AND), 3 (OR), 4 (XOR) and 7 (one's complement of op_a) clear carry, overflow and auxiliary carry.
- R9: Operation codes 8 (shift op_a left one bit) and 9 (shift op_a right one bit) fill the vacated bit with 0. Carry receives the bit shifted out.
- R10: When byte_mode is 1, only bits 7:0 of the operands are used, result[15:8] reads 0, and carry, sign and overflow refer to bit 7.
- R11: The flag word changes only on a rising clock edge with flag_we high and an operation code of 0 to 9. Codes 10 to 15 pass op_a unchanged to the result and leave the flags untouched.
- R12: The flag word places carry at bit 0, parity at bit 2, auxiliary carry at bit 4, zero at bit 6, sign at bit 7 and overflow at bit 11. All other bits read 0. An active-low asynchronous reset clears the word to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| op_sel | input | 4 | Operation code |
| byte_mode | input | 1 | 1 selects 8-bit operation |
| flag_we | input | 1 | Commit status flags on this edge |
| result | output | 16 | Combinational result |
| flags | output | 16 | Registered flag word |

## Verification
Two things meet in one cycle here. The combinational path computes a new result, while the flag register still holds the carry of the previous operation, which increment and decrement must fold back into their next flag word. The bench provokes this by committing an add or subtract that leaves a known carry and following it directly with an increment or decrement that would produce a different carry. It then checks that the committed word keeps the old carry while zero, sign, parity, auxiliary carry and overflow follow the new result. The same overlap appears when flag_we is low or the code is unused while a new result is being formed. There the bench judges that the result follows the inputs and the flag word stays exactly as before.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    localparam int FLG_CF = 0;
    localparam int FLG_PF = 2;
    localparam int FLG_AF = 4;
    localparam int FLG_ZF = 6;
    localparam int FLG_SF = 7;
    localparam int FLG_OF = 11;

    localparam logic [WORD_W-1:0] FLAG_MASK =
        (WORD_W'(1) << FLG_CF) | (WORD_W'(1) << FLG_PF) | (WORD_W'(1) << FLG_AF) |
        (WORD_W'(1) << FLG_ZF) | (WORD_W'(1) << FLG_SF) | (WORD_W'(1) << FLG_OF);

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_INC = 4'd5,
        OP_DEC = 4'd6,
        OP_NOT = 4'd7,
        OP_SHL = 4'd8,
        OP_SHR = 4'd9
    } alu_op_e;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } status_t;
endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub
    import alu16_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         byte_mode,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         aux,
    output logic         ovf
);
    localparam int BW = BYTE_W;
    localparam int NW = NIB_W;

    logic [W-1:0]  b_eff;
    logic [W:0]    full;
    logic [BW:0]   low;
    logic [NW:0]   nib;
    logic          raw_c, a_s, b_s, r_s;

    always_comb begin
        b_eff = sub ? ~b : b;
        full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        low   = {1'b0, a[BW-1:0]} + {1'b0, b_eff[BW-1:0]} + {{BW{1'b0}}, sub};
        nib   = {1'b0, a[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, sub};
        sum   = full[W-1:0];
        raw_c = byte_mode ? low[BW] : full[W];
        carry = raw_c ^ sub;
        aux   = nib[NW] ^ sub;
        a_s   = byte_mode ? a[BW-1]     : a[W-1];
        b_s   = byte_mode ? b_eff[BW-1] : b_eff[W-1];
        r_s   = byte_mode ? sum[BW-1]   : sum[W-1];
        ovf   = (a_s == b_s) && (r_s != a_s);
    end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
    import alu16_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    input  logic         byte_mode,
    output logic [W-1:0] res,
    output logic         shift_out
);
    localparam int BW = BYTE_W;

    always_comb begin
        res       = '0;
        shift_out = 1'b0;
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NOT:  res = ~a;
            OP_SHL: begin
                res       = {a[W-2:0], 1'b0};
                shift_out = byte_mode ? a[BW-1] : a[W-1];
            end
            OP_SHR: begin
                res       = byte_mode ? {{(W-BW+1){1'b0}}, a[BW-1:1]} : {1'b0, a[W-1:1]};
                shift_out = a[0];
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu16_flagreg.sv
module alu16_flagreg
    import alu16_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  status_t      nxt,
    output status_t      cur,
    output logic [W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (upd) begin
            cur <= nxt;
        end
    end

    always_comb begin
        word         = '0;
        word[FLG_CF] = cur.cf;
        word[FLG_PF] = cur.pf;
        word[FLG_AF] = cur.af;
        word[FLG_ZF] = cur.zf;
        word[FLG_SF] = cur.sf;
        word[FLG_OF] = cur.of;
    end
endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [3:0]   op_sel,
    input  logic         byte_mode,
    input  logic         flag_we,
    output logic [W-1:0] result,
    output logic [W-1:0] flags
);
    localparam int BW = BYTE_W;

    alu_op_e      op;
    logic         valid_op, is_arith, is_incdec, as_sub;
    logic [W-1:0] as_b, as_sum, lg_res, raw_res;
    logic         as_c, as_aux, as_ovf, sh_out, msb, a_msb;
    status_t      nxt, cur;

    assign op = alu_op_e'(op_sel);

    always_comb begin
        valid_op  = (op_sel <= 4'd9);
        is_incdec = (op == OP_INC) || (op == OP_DEC);
        is_arith  = (op == OP_ADD) || (op == OP_SUB) || is_incdec;
        as_sub    = (op == OP_SUB) || (op == OP_DEC);
        as_b      = is_incdec ? W'(1) : op_b;
    end

    alu16_addsub #(.W(W)) u_addsub (
        .a(op_a), .b(as_b), .sub(as_sub), .byte_mode(byte_mode),
        .sum(as_sum), .carry(as_c), .aux(as_aux), .ovf(as_ovf)
    );

    alu16_logic #(.W(W)) u_logic (
        .a(op_a), .b(op_b), .op(op), .byte_mode(byte_mode),
        .res(lg_res), .shift_out(sh_out)
    );

    always_comb begin
        if (!valid_op)     raw_res = op_a;
        else if (is_arith) raw_res = as_sum;
        else               raw_res = lg_res;

        if (byte_mode && valid_op) result = {{(W-BW){1'b0}}, raw_res[BW-1:0]};
        else                       result = raw_res;

        msb   = byte_mode ? result[BW-1] : result[W-1];
        a_msb = byte_mode ? op_a[BW-1]   : op_a[W-1];

        nxt.zf = (result == '0);
        nxt.sf = msb;
        nxt.pf = ~^result[BW-1:0];
        nxt.cf = 1'b0;
        nxt.af = 1'b0;
        nxt.of = 1'b0;
        if (is_arith) begin
            nxt.cf = is_incdec ? cur.cf : as_c;
            nxt.af = as_aux;
            nxt.of = as_ovf;
        end else if (op == OP_SHL) begin
            nxt.cf = sh_out;
            nxt.of = msb ^ sh_out;
        end else if (op == OP_SHR) begin
            nxt.cf = sh_out;
            nxt.of = a_msb;
        end
    end

    alu16_flagreg #(.W(W)) u_flags (
        .clk(clk), .rst_n(rst_n), .upd(flag_we && valid_op),
        .nxt(nxt), .cur(cur), .word(flags)
    );
endmodule

// File: rtl/alu16_sva.sv
module alu16_sva
    import alu16_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  op_sel,
    input logic        byte_mode,
    input logic        flag_we,
    input logic [15:0] result,
    input logic [15:0] flags
);
    logic commit;
    assign commit = flag_we && (op_sel <= 4'd9);

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~FLAG_MASK) == 16'h0000); // R12

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(flags)); // R11

    AST_BAD_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel > 4'd9) |=> $stable(flags)); // R11

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> flags[FLG_ZF] == ($past(result) == 16'h0000)); // R5

    AST_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> flags[FLG_PF] == ~^$past(result[7:0])); // R4

    AST_KEEP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && (op_sel == 4'd5 || op_sel == 4'd6)) |=> flags[FLG_CF] == $past(flags[FLG_CF])); // R7

    AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && (op_sel inside {4'd2, 4'd3, 4'd4, 4'd7}))
        |=> (!flags[FLG_CF] && !flags[FLG_OF] && !flags[FLG_AF])); // R8

    AST_BYTE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_mode && op_sel <= 4'd9) |-> result[15:8] == 8'h00); // R10
endmodule

bind alu16_core alu16_sva u_sva (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .byte_mode(byte_mode),
    .flag_we(flag_we), .result(result), .flags(flags)
);

// File: tb/alu16_core_bench.sv
module alu16_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0, op_b = '0;
    logic [3:0]  op_sel = '0;
    logic        byte_mode = 1'b0, flag_we = 1'b0;
    logic [15:0] result, flags;

    int n_run = 0, n_fail = 0;
    bit finished = 0;
    logic [15:0] exp_flags = 16'h0000;

    always #4 clk = ~clk;

    alu16_core u_alu16_core (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .byte_mode(byte_mode), .flag_we(flag_we), .result(result), .flags(flags)
    );

    localparam int NV = 18;
    // {op, byte_mode, a, b, expected result}
    localparam logic [52:0] VEC [NV] = '{
        {4'd0, 1'b0, 16'h1234, 16'h0001, 16'h1235},
        {4'd0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000},
        {4'd0, 1'b0, 16'h7FFF, 16'h0001, 16'h8000},
        {4'd1, 1'b0, 16'h0005, 16'h0007, 16'hFFFE},
        {4'd1, 1'b0, 16'h8000, 16'h0001, 16'h7FFF},
        {4'd1, 1'b0, 16'h0010, 16'h0001, 16'h000F},
        {4'd2, 1'b0, 16'hF0F0, 16'h3C3C, 16'h3030},
        {4'd3, 1'b0, 16'h0F00, 16'h00F0, 16'h0FF0},
        {4'd4, 1'b0, 16'hAAAA, 16'hAAAA, 16'h0000},
        {4'd7, 1'b0, 16'h00FF, 16'h1111, 16'hFF00},
        {4'd8, 1'b0, 16'h8001, 16'h0000, 16'h0002},
        {4'd9, 1'b0, 16'h0003, 16'h0000, 16'h0001},
        {4'd0, 1'b1, 16'h12FF, 16'h3401, 16'h0000},
        {4'd1, 1'b1, 16'h0080, 16'h0001, 16'h007F},
        {4'd0, 1'b0, 16'h000F, 16'h0001, 16'h0010},
        {4'd5, 1'b0, 16'h7FFF, 16'h0000, 16'h8000},
        {4'd6, 1'b0, 16'h0000, 16'h0000, 16'hFFFF},
        {4'd8, 1'b1, 16'h00C0, 16'h0000, 16'h0080}
    };

    function automatic string req_of(input logic [3:0] op, input logic bm);
        if (bm) return "R10";
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd5, 4'd6: return "R7";
            4'd8, 4'd9: return "R9";
            4'd2, 4'd3, 4'd4, 4'd7: return "R8";
            default: return "R11";
        endcase
    endfunction

    // Reference flag word built from the requirements
    function automatic logic [15:0] model(input logic [3:0] op, input logic bm,
                                          input logic [15:0] a, input logic [15:0] b,
                                          input logic prev_cf);
        int w = bm ? 8 : 16;
        int mask = (1 << w) - 1;
        int sb = 1 << (w - 1);
        int ai = int'(a) & mask;
        int bi = int'(b) & mask;
        int r = 0;
        logic cf = 0, af = 0, of = 0;
        logic [15:0] fw = '0;
        logic [7:0] lo;
        if (op == 4'd5 || op == 4'd6) bi = 1;
        case (op)
            4'd0, 4'd5: begin
                r  = (ai + bi) & mask;
                cf = (op == 4'd5) ? prev_cf : ((ai + bi) > mask);
                af = ((ai & 15) + (bi & 15)) > 15;
                of = (((ai & sb) != 0) == ((bi & sb) != 0)) && (((r & sb) != 0) != ((ai & sb) != 0));
            end
            4'd1, 4'd6: begin
                r  = (ai - bi) & mask;
                cf = (op == 4'd6) ? prev_cf : (ai < bi);
                af = (ai & 15) < (bi & 15);
                of = (((ai & sb) != 0) != ((bi & sb) != 0)) && (((r & sb) != 0) != ((ai & sb) != 0));
            end
            4'd2: r = ai & bi;
            4'd3: r = ai | bi;
            4'd4: r = ai ^ bi;
            4'd7: r = (~ai) & mask;
            4'd8: begin
                r  = (ai << 1) & mask;
                cf = (ai & sb) != 0;
                of = ((r & sb) != 0) ^ cf;
            end
            4'd9: begin
                r  = ai >> 1;
                cf = ai[0];
                of = (ai & sb) != 0;
            end
            default: r = 0;
        endcase
        lo = 8'(r);
        fw[0]  = cf;
        fw[2]  = ~^lo;
        fw[4]  = af;
        fw[6]  = (r == 0);
        fw[7]  = (r & sb) != 0;
        fw[11] = of;
        return fw;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] op, input logic bm, input logic [15:0] a,
                       input logic [15:0] b, input logic we, input logic [15:0] exp_res,
                       input string req);
        @(negedge clk);
        op_sel = op; byte_mode = bm; op_a = a; op_b = b; flag_we = we;
        #1;
        check(req, "result", result, exp_res);
        if (we && op <= 4'd9) exp_flags = model(op, bm, a, b, exp_flags[0]);
        @(posedge clk);
        #1;
        check(req, "flags R3/R4/R5/R6/R12", flags, exp_flags);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R12", "reset flags", flags, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run(VEC[i][52:49], VEC[i][48], VEC[i][47:32], VEC[i][31:16], 1'b1,
                VEC[i][15:0], req_of(VEC[i][52:49], VEC[i][48]));
        end

        // R7: carry from the previous add survives an increment
        run(4'd0, 1'b0, 16'hFFFF, 16'h0001, 1'b1, 16'h0000, "R1");
        run(4'd5, 1'b0, 16'h00FF, 16'h0000, 1'b1, 16'h0100, "R7");
        check("R7", "carry kept", {15'h0, flags[0]}, 16'h0001);
        run(4'd1, 1'b0, 16'h0003, 16'h0003, 1'b1, 16'h0000, "R2");
        run(4'd6, 1'b0, 16'h0001, 16'h0000, 1'b1, 16'h0000, "R7");
        // R10: byte decrement wraps inside the low byte
        run(4'd6, 1'b1, 16'hAB00, 16'h0000, 1'b1, 16'h00FF, "R10");
        run(4'd9, 1'b1, 16'hFF81, 16'h0000, 1'b1, 16'h0040, "R10");
        // R11: no strobe, flags hold while the result moves
        run(4'd0, 1'b0, 16'h7FFF, 16'h7FFF, 1'b0, 16'hFFFE, "R11");
        // R11: unused code passes op_a and leaves flags alone
        run(4'hC, 1'b0, 16'h5A5A, 16'h1234, 1'b1, 16'h5A5A, "R11");
        run(4'hF, 1'b1, 16'h0000, 16'h0000, 1'b1, 16'h0000, "R11");
        // R6: word overflow on subtract of different signs
        run(4'd1, 1'b0, 16'h7FFF, 16'hFFFF, 1'b1, 16'h8000, "R6");
        // R12: asynchronous reset clears the word
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R12", "async reset", flags, 16'h0000);
        exp_flags = 16'h0000;
        @(negedge clk);
        rst_n = 1'b1;

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule